// File: doc/BRIEF.md
# Converter Power-Mode Manager with Wake-Up Timer

This block follows the power state of a sampling converter. Two level inputs ask for the low-power states: `stby_i` for the deep sleep state and `nap_i` for the light one. A configuration input, `ext_ref_i`, says whether an external reference is in use. When both requests go low, the block does not return to normal operation at once. It first runs a wake-up timer, and the length of that timer depends on which low-power state is being left and on the reference selection. `ready_o` is high only when a conversion may legally start. A conversion started any earlier would give invalid data.

The block also watches two illegal uses and records each in its own sticky flag. The first is a convert-start request while the block is not ready. The second is a light-sleep request while the internal reference is selected, which is a forbidden combination. Wake-up lengths are parameters counted in clock cycles. With a 50 MHz clock the defaults are 15 cycles (300 ns) for light sleep, 4000 cycles (80 µs) for deep sleep with an external reference, and 25,000,000 cycles (500 ms) for deep sleep with the internal reference.

Top module: `pwr_wake_mgr`

## Requirements
- R1: After reset, `state_o` is 0 (run), `ready_o` is 1, and both violation flags are 0.
- R2: `state_o` encodes run=0, nap=1, standby=2, waking=3. A clock edge that samples `stby_i` high moves the block to standby (2), even if `nap_i` is also high.
- R3: A clock edge that samples `nap_i` high and `stby_i` low moves the block to nap (1).
- R4: Leaving nap, when no standby has occurred since the last run state, enters waking (3). `ready_o` then rises NAP_WAKE_CYC edges after the exit edge, which is the first edge that samples both requests low.
- R5: Leaving standby with `ext_ref_i` high at the exit edge makes `ready_o` rise STBY_EXT_CYC edges after that edge.
- R6: Leaving standby with `ext_ref_i` low at the exit edge makes `ready_o` rise STBY_INT_CYC edges after that edge.
- R7: Once standby has been entered, the standby wake-up length applies to every later exit until the run state is reached, including an exit from nap.
- R8: A request for a low-power state while waking aborts the wake-up. The block enters the requested state, `ready_o` stays 0, and a full wake-up is needed afterwards.
- R9: An edge that samples `conv_i` high while `ready_o` is 0 sets `viol_early_o`. A request while `ready_o` is 1 has no effect on the flags.
- R10: An edge that samples `nap_i` high while `ext_ref_i` is low sets `viol_ref_o`.
- R11: Both violation flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Standby (deep sleep) request level |
| nap_i | input | 1 | Nap (light sleep) request level |
| ext_ref_i | input | 1 | 1 = external reference in use, 0 = internal reference |
| conv_i | input | 1 | Convert-start request, sampled each edge |
| state_o | output | 2 | Power state: 0 run, 1 nap, 2 standby, 3 waking |
| ready_o | output | 1 | A conversion may start |
| viol_early_o | output | 1 | Sticky: convert request while not ready |
| viol_ref_o | output | 1 | Sticky: nap request with the internal reference |

## Verification
The bench builds the block with wake-up lengths of 3, 5 and 9 cycles for nap, external-reference standby and internal-reference standby. The three lengths are distinct, so a swap between any two of them changes the observed rise time of `ready_o`. These short lengths also bring every transition within a few cycles: the off-by-one boundary at the end of the timer, the standby-then-nap carry-over, and a wake-up aborted midway. The default 500 ms length would leave all of these out of reach.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_NAP  = 2'd1,
    PM_STBY = 2'd2,
    PM_WAKE = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_wake_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stby_i,
  input  logic      nap_i,
  input  logic      wake_done_i,
  output pm_state_e state_o,
  output logic      wake_start_o,
  output logic      deep_o
);
  pm_state_e state_q, state_d;
  logic      deep_q, deep_d;

  always_comb begin
    state_d      = state_q;
    wake_start_o = 1'b0;
    if (stby_i)      state_d = PM_STBY;   // standby wins over nap
    else if (nap_i)  state_d = PM_NAP;
    else begin
      unique case (state_q)
        PM_NAP, PM_STBY: begin
          state_d      = PM_WAKE;
          wake_start_o = 1'b1;
        end
        PM_WAKE: if (wake_done_i) state_d = PM_RUN;
        default: ;
      endcase
    end
  end

  // deep stays set from standby entry until run is reached
  always_comb begin
    deep_d = deep_q;
    if (state_d == PM_STBY)     deep_d = 1'b1;
    else if (state_d == PM_RUN) deep_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_RUN;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
    end
  end

  assign state_o = state_q;
  assign deep_o  = deep_q;

  assert_stby_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> state_q == PM_STBY);

  assert_nap_enter_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nap_i && !stby_i) |=> state_q == PM_NAP);

  assert_lp_exit_wakes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == PM_NAP || state_q == PM_STBY) && !stby_i && !nap_i) |=> state_q == PM_WAKE);

  assert_deep_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_STBY) |-> deep_q);
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pwr_viol_track.sv
module pwr_viol_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  input  logic ready_i,
  input  logic nap_i,
  input  logic ext_ref_i,
  output logic early_o,
  output logic ref_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_o <= 1'b0;
      ref_o   <= 1'b0;
    end else begin
      if (conv_i && !ready_i) early_o <= 1'b1;
      if (nap_i && !ext_ref_i) ref_o  <= 1'b1;
    end
  end

  assert_early_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !ready_i) |=> early_o);

  assert_ref_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nap_i && !ext_ref_i) |=> ref_o);

  assert_early_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |=> early_o);

  assert_ref_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> ref_o);
endmodule

// File: rtl/pwr_wake_mgr.sv
module pwr_wake_mgr
  import pwr_wake_pkg::*;
#(
  parameter int NAP_WAKE_CYC = 15,
  parameter int STBY_EXT_CYC = 4000,
  parameter int STBY_INT_CYC = 25_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_i,
  input  logic       nap_i,
  input  logic       ext_ref_i,
  input  logic       conv_i,
  output logic [1:0] state_o,
  output logic       ready_o,
  output logic       viol_early_o,
  output logic       viol_ref_o
);
  localparam int MAX_A   = (NAP_WAKE_CYC > STBY_EXT_CYC) ? NAP_WAKE_CYC : STBY_EXT_CYC;
  localparam int MAX_CYC = (MAX_A > STBY_INT_CYC) ? MAX_A : STBY_INT_CYC;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] NAP_LD  = CNT_W'(NAP_WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] SEXT_LD = CNT_W'(STBY_EXT_CYC - 1);
  localparam logic [CNT_W-1:0] SINT_LD = CNT_W'(STBY_INT_CYC - 1);

  pm_state_e        state;
  logic             wake_start, deep, wake_done;
  logic [CNT_W-1:0] load_val;

  // length chosen by the state being left and reference at the exit edge
  always_comb begin
    if (!deep)          load_val = NAP_LD;
    else if (ext_ref_i) load_val = SEXT_LD;
    else                load_val = SINT_LD;
  end

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stby_i       (stby_i),
    .nap_i        (nap_i),
    .wake_done_i  (wake_done),
    .state_o      (state),
    .wake_start_o (wake_start),
    .deep_o       (deep)
  );

  pwr_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wake_start),
    .load_val_i (load_val),
    .run_i      (state == PM_WAKE),
    .done_o     (wake_done)
  );

  assign ready_o = (state == PM_RUN);
  assign state_o = state;

  pwr_viol_track u_viol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .conv_i    (conv_i),
    .ready_i   (ready_o),
    .nap_i     (nap_i),
    .ext_ref_i (ext_ref_i),
    .early_o   (viol_early_o),
    .ref_o     (viol_ref_o)
  );

  assert_ready_via_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(state) == PM_WAKE && $past(wake_done));

  assert_lp_not_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_i || nap_i) |=> !ready_o);
endmodule

// File: tb/pwr_wake_mgr_tb.sv
module pwr_wake_mgr_tb;
  localparam int NAP_C  = 3;
  localparam int SEXT_C = 5;
  localparam int SINT_C = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b0, nap = 1'b0, ext = 1'b1, conv = 1'b0;
  logic [1:0] st;
  logic rdy, v_early, v_ref;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pwr_wake_mgr #(.NAP_WAKE_CYC(NAP_C), .STBY_EXT_CYC(SEXT_C), .STBY_INT_CYC(SINT_C)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby), .nap_i(nap), .ext_ref_i(ext),
    .conv_i(conv), .state_o(st), .ready_o(rdy), .viol_early_o(v_early), .viol_ref_o(v_ref)
  );

  // {stby, nap, ext, conv, expected state}
  localparam logic [5:0] VEC [14] = '{
    6'b0010_00, 6'b0110_01, 6'b0110_01, 6'b0010_11, 6'b0010_11, 6'b0010_11,
    6'b0010_00, 6'b1110_10, 6'b0010_11, 6'b0010_11, 6'b0010_11, 6'b0010_11,
    6'b0010_11, 6'b0010_00
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic n, input logic e, input logic c);
    stby = s; nap = n; ext = e; conv = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ready(input logic e, output int cnt);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b0, e, 1'b0);
      cnt++;
      if (rdy) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stby = 1'b0; nap = 1'b0; ext = 1'b1; conv = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    chk("R1 state", st, 0);
    chk("R1 ready", rdy, 1);
    chk("R1 early", v_early, 0);
    chk("R1 ref", v_ref, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R2/R3/R4/R5 vec%0d state", i), st, VEC[i][1:0]);
      chk($sformatf("R4/R5 vec%0d ready", i), rdy, VEC[i][1:0] == 2'd0);
    end

    // R4 nap exit length
    step(0, 1, 1, 0);
    wait_ready(1'b1, n);
    chk("R4 nap wake edges", n, NAP_C + 1);

    // R5 standby ext
    step(1, 0, 1, 0);
    wait_ready(1'b1, n);
    chk("R5 stby ext wake edges", n, SEXT_C + 1);

    // R6 standby internal reference
    step(1, 0, 0, 0);
    chk("R6 state stby", st, 2);
    wait_ready(1'b0, n);
    chk("R6 stby int wake edges", n, SINT_C + 1);

    // R7 standby then nap keeps standby length
    step(1, 0, 1, 0);
    step(0, 1, 1, 0);
    chk("R7 state nap", st, 1);
    wait_ready(1'b1, n);
    chk("R7 deep wake edges", n, SEXT_C + 1);

    // R8 abort wake
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R8 waking", st, 3);
    step(1, 0, 1, 0);
    chk("R8 aborted state", st, 2);
    chk("R8 ready low", rdy, 0);
    wait_ready(1'b1, n);
    chk("R8 full wake after abort", n, SEXT_C + 1);

    // R9 conv while ready has no effect, while not ready sets flag
    step(0, 0, 1, 1);
    chk("R9 legal conv no flag", v_early, 0);
    chk("R9 legal conv still ready", rdy, 1);
    step(1, 0, 1, 0);
    step(1, 0, 1, 1);
    chk("R9 early flag", v_early, 1);
    chk("R10 ref flag untouched", v_ref, 0);
    wait_ready(1'b1, n);
    chk("R11 early sticky", v_early, 1);

    // R10 nap with internal reference
    step(0, 1, 0, 0);
    chk("R10 ref flag", v_ref, 1);
    chk("R10 state nap", st, 1);
    wait_ready(1'b1, n);
    chk("R11 ref sticky", v_ref, 1);

    // R11/R1 cleared only by reset
    do_reset();
    chk("R11 early cleared by reset", v_early, 0);
    chk("R11 ref cleared by reset", v_ref, 0);
    chk("R1 ready after reset", rdy, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule